// File: doc/BRIEF.md
# Triplicated Output Voting Stage

This block sits at the edge of a triple-redundant design and turns three copies of a multi-bit result into outputs that survive upsets. Each of the three lanes runs on its own clock and has its own majority voter, so the voting logic is itself tripled and a fault inside one voter corrupts only that lane's voted bus. Voting is done bit by bit, so faults that land on different bits in different lanes are all outvoted.

Each lane also sends its own copy off chip on its own set of pad drivers, and the three pad sets are tied together on the board. A per-lane minority check compares every bit of the lane's copy against the other two copies. A bit that disagrees has its output enable dropped, so the pad goes to high impedance and the two agreeing lanes drive the shared node. A registered per-lane flag reports that at least one bit of that lane was in the minority on the last sample.

All outputs of a lane are registered on that lane's clock, one cycle after the inputs are sampled.

Top module: `tmr_out_stage`

## Requirements
- R1: On each rising edge of its own clock, lane k loads its voted bus with the bitwise majority of the three input buses, so the voted value appears one cycle after the inputs are sampled.
- R2: Voting is per bit: when each bit position is wrong in at most one lane, every voted bus equals the value carried by the agreeing lanes, even when all three lanes are wrong on different bits.
- R3: Lane k's pad data bus is its own input bus, registered on lane k's clock.
- R4: Lane k's pad output enable bit i is 1 (drive) when lane k's input bit i equals at least one of the other two lanes' bit i, and 0 (high impedance) when it differs from both.
- R5: Lane k's mismatch flag is 1 when any bit of lane k was in the minority on the last sample, else 0, registered with the same latency as the other outputs.
- R6: While reset (active low, sampled on each lane's clock) is asserted, every voted bus, pad data bus, output enable bus and mismatch flag is 0.
- R7: A lane's outputs change only on its own clock edge: with one lane's clock stopped, that lane's outputs hold while the other lanes keep updating.
- R8: When two lanes carry the same wrong value on a bit, the voted buses follow those two lanes, their pads keep driving that bit, and the one correct lane is tri-stated on that bit and flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Clock of lane A |
| clk_b | input | 1 | Clock of lane B |
| clk_c | input | 1 | Clock of lane C |
| rst_n | input | 1 | Active-low reset, sampled on each lane clock |
| in_a | input | WIDTH | Result copy from lane A |
| in_b | input | WIDTH | Result copy from lane B |
| in_c | input | WIDTH | Result copy from lane C |
| voted_a | output | WIDTH | Majority result from lane A's voter |
| voted_b | output | WIDTH | Majority result from lane B's voter |
| voted_c | output | WIDTH | Majority result from lane C's voter |
| pad_d_a | output | WIDTH | Pad data of lane A |
| pad_d_b | output | WIDTH | Pad data of lane B |
| pad_d_c | output | WIDTH | Pad data of lane C |
| pad_oe_a | output | WIDTH | Per-bit pad enable of lane A, 1 drives |
| pad_oe_b | output | WIDTH | Per-bit pad enable of lane B, 1 drives |
| pad_oe_c | output | WIDTH | Per-bit pad enable of lane C, 1 drives |
| mis_a | output | 1 | Lane A had a minority bit on the last sample |
| mis_b | output | 1 | Lane B had a minority bit on the last sample |
| mis_c | output | 1 | Lane C had a minority bit on the last sample |

## Verification
The bench targets a single flipped bit in one lane, three lanes each wrong on a different bit, and two lanes wrong together on the same bit. A voter that compared whole words instead of bits would pass the single-bit case but corrupt the voted bus when faults are spread over lanes, and a minority check built from the wrong pair of peers would tri-state a correct lane or flag the wrong one when two lanes agree on an error. Stopping one lane's clock exposes any lane that is wired to a neighbour's clock, since its outputs would move when they must hold.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

  localparam int unsigned NUM_LANES = 3;

  // Bitwise two-out-of-three vote.
  function automatic logic [63:0] vote3(input logic [63:0] x,
                                        input logic [63:0] y,
                                        input logic [63:0] z);
    return (x & y) | (y & z) | (x & z);
  endfunction

  // Bits where `own` disagrees with both peers.
  function automatic logic [63:0] odd_bits(input logic [63:0] own,
                                           input logic [63:0] p0,
                                           input logic [63:0] p1);
    return (own ^ p0) & (own ^ p1);
  endfunction

endpackage

// File: rtl/tmr_majority_voter.sv
module tmr_majority_voter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] z_i,
  output logic [WIDTH-1:0] maj_o
);
  import tmr_vote_pkg::*;

  localparam int unsigned PAD = 64 - WIDTH;

  logic [63:0] wide;

  always_comb begin
    wide  = vote3({{PAD{1'b0}}, x_i}, {{PAD{1'b0}}, y_i}, {{PAD{1'b0}}, z_i});
    maj_o = wide[WIDTH-1:0];
  end

  always_comb begin
    a_r2_maj_bit_consistent: assert (((x_i ^ maj_o) & (y_i ^ maj_o) & (z_i ^ maj_o)) == '0)
      else $error("voter output bit disagrees with all three inputs");
  end

endmodule

// File: rtl/tmr_minority_guard.sv
module tmr_minority_guard #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] own_i,
  input  logic [WIDTH-1:0] peer0_i,
  input  logic [WIDTH-1:0] peer1_i,
  output logic [WIDTH-1:0] odd_o,
  output logic             any_odd_o
);
  import tmr_vote_pkg::*;

  localparam int unsigned PAD = 64 - WIDTH;

  logic [63:0] wide;

  always_comb begin
    wide      = odd_bits({{PAD{1'b0}}, own_i}, {{PAD{1'b0}}, peer0_i}, {{PAD{1'b0}}, peer1_i});
    odd_o     = wide[WIDTH-1:0];
    any_odd_o = |odd_o;
  end

endmodule

// File: rtl/tmr_vote_lane.sv
module tmr_vote_lane #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] own_i,
  input  logic [WIDTH-1:0] peer0_i,
  input  logic [WIDTH-1:0] peer1_i,
  output logic [WIDTH-1:0] voted_o,
  output logic [WIDTH-1:0] pad_d_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic             mis_o
);
  import tmr_vote_pkg::*;

  localparam int unsigned PAD = 64 - WIDTH;

  // Named internal events for the checks below.
  logic [WIDTH-1:0] maj_w;
  logic [WIDTH-1:0] odd_w;
  logic             any_odd_w;
  logic             live_q;

  tmr_majority_voter #(.WIDTH(WIDTH)) u_voter (
    .x_i  (own_i),
    .y_i  (peer0_i),
    .z_i  (peer1_i),
    .maj_o(maj_w)
  );

  tmr_minority_guard #(.WIDTH(WIDTH)) u_guard (
    .own_i    (own_i),
    .peer0_i  (peer0_i),
    .peer1_i  (peer1_i),
    .odd_o    (odd_w),
    .any_odd_o(any_odd_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      voted_o  <= '0;
      pad_d_o  <= '0;
      pad_oe_o <= '0;
      mis_o    <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      voted_o  <= maj_w;
      pad_d_o  <= own_i;
      pad_oe_o <= ~odd_w;
      mis_o    <= any_odd_w;
      live_q   <= 1'b1;
    end
  end

  // R1: voted bus is the majority of the inputs sampled one lane tick earlier.
  a_r1_voted_follows: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> voted_o == WIDTH'(vote3({{PAD{1'b0}}, $past(own_i)},
                                       {{PAD{1'b0}}, $past(peer0_i)},
                                       {{PAD{1'b0}}, $past(peer1_i)})))
    else $error("voted bus is not the majority of the previous sample");

  // R3: pad data mirrors the lane's own input one tick later.
  a_r3_pad_data: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> pad_d_o == $past(own_i))
    else $error("pad data does not follow own input");

  // R4: an enabled pad bit always carries the voted value.
  a_r4_oe_agree: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_d_o ^ voted_o) & pad_oe_o) == '0)
    else $error("enabled pad bit differs from voted bit");

  // R5: flag is set exactly when some pad bit is tri-stated.
  a_r5_flag_oe: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> mis_o == !(&pad_oe_o))
    else $error("mismatch flag out of step with pad enables");

endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             clk_c,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_a,
  input  logic [WIDTH-1:0] in_b,
  input  logic [WIDTH-1:0] in_c,
  output logic [WIDTH-1:0] voted_a,
  output logic [WIDTH-1:0] voted_b,
  output logic [WIDTH-1:0] voted_c,
  output logic [WIDTH-1:0] pad_d_a,
  output logic [WIDTH-1:0] pad_d_b,
  output logic [WIDTH-1:0] pad_d_c,
  output logic [WIDTH-1:0] pad_oe_a,
  output logic [WIDTH-1:0] pad_oe_b,
  output logic [WIDTH-1:0] pad_oe_c,
  output logic             mis_a,
  output logic             mis_b,
  output logic             mis_c
);
  import tmr_vote_pkg::*;

  logic [WIDTH-1:0] lane_in  [NUM_LANES];
  logic             lane_clk [NUM_LANES];
  logic [WIDTH-1:0] lane_vot [NUM_LANES];
  logic [WIDTH-1:0] lane_pd  [NUM_LANES];
  logic [WIDTH-1:0] lane_oe  [NUM_LANES];
  logic             lane_mis [NUM_LANES];

  always_comb begin
    lane_in[0]  = in_a;
    lane_in[1]  = in_b;
    lane_in[2]  = in_c;
    lane_clk[0] = clk_a;
    lane_clk[1] = clk_b;
    lane_clk[2] = clk_c;
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int unsigned P0 = (k + 1) % NUM_LANES;
    localparam int unsigned P1 = (k + 2) % NUM_LANES;

    tmr_vote_lane #(.WIDTH(WIDTH)) u_lane (
      .clk     (lane_clk[k]),
      .rst_n   (rst_n),
      .own_i   (lane_in[k]),
      .peer0_i (lane_in[P0]),
      .peer1_i (lane_in[P1]),
      .voted_o (lane_vot[k]),
      .pad_d_o (lane_pd[k]),
      .pad_oe_o(lane_oe[k]),
      .mis_o   (lane_mis[k])
    );
  end

  always_comb begin
    voted_a  = lane_vot[0];
    voted_b  = lane_vot[1];
    voted_c  = lane_vot[2];
    pad_d_a  = lane_pd[0];
    pad_d_b  = lane_pd[1];
    pad_d_c  = lane_pd[2];
    pad_oe_a = lane_oe[0];
    pad_oe_b = lane_oe[1];
    pad_oe_c = lane_oe[2];
    mis_a    = lane_mis[0];
    mis_b    = lane_mis[1];
    mis_c    = lane_mis[2];
  end

endmodule

// File: tb/sim_tmr_out_stage.sv
`timescale 1ns/1ps
module sim_tmr_out_stage;
  localparam int W = 8;

  logic clk = 1'b0;
  logic en_a = 1'b1, en_b = 1'b1, en_c = 1'b1;
  logic clk_a, clk_b, clk_c;
  logic rst_n = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0, in_c = '0;
  logic [W-1:0] voted_a, voted_b, voted_c;
  logic [W-1:0] pad_d_a, pad_d_b, pad_d_c;
  logic [W-1:0] pad_oe_a, pad_oe_b, pad_oe_c;
  logic mis_a, mis_b, mis_c;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  assign clk_a = clk & en_a;
  assign clk_b = clk & en_b;
  assign clk_c = clk & en_c;

  tmr_out_stage #(.WIDTH(W)) u0 (
    .clk_a(clk_a), .clk_b(clk_b), .clk_c(clk_c), .rst_n(rst_n),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .voted_a(voted_a), .voted_b(voted_b), .voted_c(voted_c),
    .pad_d_a(pad_d_a), .pad_d_b(pad_d_b), .pad_d_c(pad_d_c),
    .pad_oe_a(pad_oe_a), .pad_oe_b(pad_oe_b), .pad_oe_c(pad_oe_c),
    .mis_a(mis_a), .mis_b(mis_b), .mis_c(mis_c)
  );

  // Reference majority by counting ones per bit.
  function automatic logic [W-1:0] ref_maj(logic [W-1:0] x, logic [W-1:0] y, logic [W-1:0] z);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (int'(x[i]) + int'(y[i]) + int'(z[i])) >= 2;
    return r;
  endfunction

  // Reference enable: drive when own bit matches the per-bit count winner.
  function automatic logic [W-1:0] ref_oe(logic [W-1:0] own, logic [W-1:0] m);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (own[i] == m[i]);
    return r;
  endfunction

  task automatic chk(string req, int lane, logic [W-1:0] ev, logic [W-1:0] ed,
                     logic [W-1:0] eo, logic ef);
    logic [W-1:0] av, ad, ao;
    logic af;
    case (lane)
      0: begin av = voted_a; ad = pad_d_a; ao = pad_oe_a; af = mis_a; end
      1: begin av = voted_b; ad = pad_d_b; ao = pad_oe_b; af = mis_b; end
      default: begin av = voted_c; ad = pad_d_c; ao = pad_oe_c; af = mis_c; end
    endcase
    n_run++;
    if (av !== ev || ad !== ed || ao !== eo || af !== ef) begin
      n_fail++;
      $display("FAIL %s lane%0d: voted=%h pad=%h oe=%h mis=%b expected voted=%h pad=%h oe=%h mis=%b",
               req, lane, av, ad, ao, af, ev, ed, eo, ef);
    end
  endtask

  task automatic chk_all(string req, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] m;
    m = ref_maj(a, b, c);
    chk(req, 0, m, a, ref_oe(a, m), ref_oe(a, m) != '1);
    chk(req, 1, m, b, ref_oe(b, m), ref_oe(b, m) != '1);
    chk(req, 2, m, c, ref_oe(c, m), ref_oe(c, m) != '1);
  endtask

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    @(negedge clk);
    in_a = a; in_b = b; in_c = c;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_a = 8'hA5; in_b = 8'h3C; in_c = 8'hFF;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) chk("R6", k, '0, '0, '0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_clean;
    drive(8'h5A, 8'h5A, 8'h5A);
    chk_all("R1", 8'h5A, 8'h5A, 8'h5A);
    chk("R3", 1, 8'h5A, 8'h5A, 8'hFF, 1'b0);
    drive(8'hFF, 8'hFF, 8'hFF);
    chk_all("R1", 8'hFF, 8'hFF, 8'hFF);
    drive(8'h00, 8'h00, 8'h00);
    chk_all("R1", 8'h00, 8'h00, 8'h00);
  endtask

  task automatic t_single_fault;
    drive(8'h96 ^ 8'h08, 8'h96, 8'h96);
    chk("R4", 0, 8'h96, 8'h9E, 8'hF7, 1'b1);
    chk("R5", 1, 8'h96, 8'h96, 8'hFF, 1'b0);
    chk("R5", 2, 8'h96, 8'h96, 8'hFF, 1'b0);
    drive(8'h96, 8'h96, 8'h96 ^ 8'h80);
    chk_all("R4", 8'h96, 8'h96, 8'h16);
  endtask

  task automatic t_spread_faults;
    drive(8'hC3 ^ 8'h01, 8'hC3 ^ 8'h20, 8'hC3 ^ 8'h80);
    chk("R2", 0, 8'hC3, 8'hC2, 8'hFE, 1'b1);
    chk("R2", 1, 8'hC3, 8'hE3, 8'hDF, 1'b1);
    chk("R2", 2, 8'hC3, 8'h43, 8'h7F, 1'b1);
  endtask

  task automatic t_dual_fault;
    drive(8'h3C, 8'h3C ^ 8'h04, 8'h3C ^ 8'h04);
    chk("R8", 0, 8'h38, 8'h3C, 8'hFB, 1'b1);
    chk("R8", 1, 8'h38, 8'h38, 8'hFF, 1'b0);
    chk("R8", 2, 8'h38, 8'h38, 8'hFF, 1'b0);
    drive(8'h3C ^ 8'h41, 8'h3C ^ 8'h10, 8'h3C ^ 8'h51);
    chk_all("R8", 8'h7D, 8'h2C, 8'h6D);
  endtask

  task automatic t_clock_independence;
    drive(8'h11, 8'h11, 8'h11);
    @(negedge clk);
    en_b = 1'b0;
    drive(8'hE7, 8'hE7, 8'hE6);
    chk("R7", 0, 8'hE7, 8'hE7, 8'hFF, 1'b0);
    chk("R7", 1, 8'h11, 8'h11, 8'hFF, 1'b0);
    chk("R7", 2, 8'hE7, 8'hE6, 8'hFE, 1'b1);
    en_b = 1'b1;
    @(negedge clk);
    chk("R7", 1, 8'hE7, 8'hE7, 8'hFF, 1'b0);
  endtask

  initial begin
    t_reset();
    t_clean();
    t_single_fault();
    t_spread_faults();
    t_dual_fault();
    t_clock_independence();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule